// File: doc/BRIEF.md
# Conversion Result FIFO with Serial Readout

This block sits between a converter's result producers and a serial host port. Conversion results (10 bits each) arrive as single-cycle strobes and enter a sixteen-deep queue. When that queue is full, a new arrival pushes out the oldest entry. Temperature results (a 10-bit value plus 2 fractional sub-bits) go to a single slot of their own. A newer temperature result replaces an unread older one.

The host reads through a chip-select-framed serial port. Every falling edge of chip-select loads one 16-bit frame, which is shifted out MSB first. A pending temperature result is always served before any queued conversion result. With nothing stored, the frame is all zeros. An entry is released only after all sixteen bits of its frame have been clocked out. A frame cut short leaves the entry in place for the next read. The chip-select and serial clock pins are sampled in the system clock domain, so the serial clock must run at less than half the system clock rate.

Top module: `result_fifo_serial`

## Requirements
- R1: The queue stores up to 16 conversion results, and `adc_count` reports how many are stored (0 to 16).
- R2: A conversion strobe that arrives while the queue holds 16 entries, with no frame completing in that cycle, discards the oldest entry and stores the new one. The count stays at 16.
- R3: A conversion result D is sent as the 16-bit frame {4'b0000, D[9:0], 2'b00}.
- R4: The temperature input carries the value in bits [11:2] and the sub-bits in bits [1:0]. It is sent as the frame {4'b0000, value[9:0], sub[1:0]}.
- R5: When a temperature result is stored at the moment chip-select falls, that frame carries the temperature result, ahead of any queued conversion result.
- R6: A temperature strobe replaces any unread temperature value and sets `tmp_valid`.
- R7: Each chip-select falling edge loads the oldest available frame. Bit 15 appears on `sdo` first. `sdo` advances one bit after each falling serial-clock edge and is stable across the rising edge.
- R8: `sdo` is 0 whenever `cs_n` is high.
- R9: With the queue empty and no temperature result, every bit of the frame is 0.
- R10: An entry leaves the queue, or the temperature slot clears, only at the 16th rising serial-clock edge of its frame. A frame ended early by chip-select rising keeps the entry.
- R11: When a frame completes while the queue is full, a conversion strobe in that same cycle is stored without loss. The count stays at 16.
- R12: After reset, `adc_count` is 0, `tmp_valid` is 0 and `sdo` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| adc_wr | input | 1 | Conversion result strobe |
| adc_data | input | 10 | Conversion result |
| tmp_wr | input | 1 | Temperature result strobe |
| tmp_data | input | 12 | Temperature value [11:2] and sub-bits [1:0] |
| cs_n | input | 1 | Serial chip-select, active low |
| sclk | input | 1 | Serial clock |
| sdo | output | 1 | Serial data out |
| adc_count | output | 5 | Number of stored conversion results |
| tmp_valid | output | 1 | Temperature result pending |

## Verification
The bench overfills the queue by two entries and checks that the frame which follows carries the third-oldest result. A design that refused writes when full would return the first result instead. It also cuts a frame after eight bits and then reads that entry again; a design that dequeued on chip-select would skip a result at that point. It places a conversion strobe in the exact cycle a frame completes on a full queue, then drains all sixteen entries in order, which exposes any lost or duplicated entry. Back-to-back temperature writes and frames read with nothing stored complete the set: these catch a stale temperature value and non-zero data sent when empty.

// File: rtl/rfs_pkg.sv
package rfs_pkg;
  localparam int RES_W   = 10;
  localparam int SUB_W   = 2;
  localparam int LEAD_W  = 4;
  localparam int FRAME_W = LEAD_W + RES_W + SUB_W;

  typedef enum logic [1:0] {SRC_NONE, SRC_TMP, SRC_ADC} src_e;

  function automatic logic [FRAME_W-1:0] adc_frame(input logic [RES_W-1:0] d);
    return {{LEAD_W{1'b0}}, d, {SUB_W{1'b0}}};
  endfunction

  function automatic logic [FRAME_W-1:0] tmp_frame(input logic [RES_W+SUB_W-1:0] t);
    return {{LEAD_W{1'b0}}, t};
  endfunction
endpackage

// File: rtl/rfs_ring.sv
module rfs_ring #(
  parameter int DEPTH = 16,
  parameter int W     = 10,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic [CW-1:0] count,
  output logic          ovw,
  output logic          popped
);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] head, tail;
  logic          drop;

  assign popped = pop && (count != '0);
  assign ovw    = push && !popped && (count == FULL);
  assign drop   = popped || ovw;
  assign dout   = mem[head];

  always_ff @(posedge clk) begin
    if (push) mem[tail] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head  <= '0;
      tail  <= '0;
      count <= '0;
    end else begin
      if (push) tail <= nxt(tail);
      if (drop) head <= nxt(head);
      if (push && !drop)      count <= count + 1'b1;
      else if (!push && drop) count <= count - 1'b1;
    end
  end
endmodule

// File: rtl/rfs_tslot.sv
module rfs_tslot #(
  parameter int TW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [TW-1:0] din,
  input  logic          sel,
  input  logic          rel,
  output logic          valid,
  output logic [TW-1:0] dout
);
  logic fresh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      fresh <= 1'b0;
      dout  <= '0;
    end else if (wr) begin
      dout  <= din;
      valid <= 1'b1;
      fresh <= 1'b1;
    end else begin
      if (sel) fresh <= 1'b0;
      if (rel && !fresh) valid <= 1'b0;
    end
  end
endmodule

// File: rtl/rfs_shifter.sv
module rfs_shifter #(
  parameter int FW = 16,
  localparam int BW = $clog2(FW + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          sclk,
  input  logic [FW-1:0] word,
  output logic          load,
  output logic          done,
  output logic          sdo
);
  localparam logic [BW-1:0] LASTB = BW'(FW - 1);
  localparam logic [BW-1:0] ENDB  = BW'(FW);

  logic          cs_q, sclk_q, active;
  logic          sc_rise, sc_fall;
  logic [BW-1:0] bitcnt;
  logic [FW-1:0] shreg;

  assign load    = cs_q && !cs_n;
  assign sc_rise = !sclk_q && sclk && !cs_n;
  assign sc_fall = sclk_q && !sclk && !cs_n;
  assign done    = !load && sc_rise && (bitcnt == LASTB);
  assign sdo     = active && !cs_n && shreg[FW-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q   <= 1'b1;
      sclk_q <= 1'b0;
      active <= 1'b0;
      bitcnt <= '0;
      shreg  <= '0;
    end else begin
      cs_q   <= cs_n;
      sclk_q <= sclk;
      if (cs_n) active <= 1'b0;
      if (load) begin
        shreg  <= word;
        bitcnt <= '0;
        active <= 1'b1;
      end else begin
        if (sc_rise && bitcnt != ENDB) bitcnt <= bitcnt + 1'b1;
        if (sc_fall) shreg <= {shreg[FW-2:0], 1'b0};
      end
    end
  end
endmodule

// File: rtl/result_fifo_serial.sv
module result_fifo_serial
  import rfs_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   adc_wr,
  input  logic [RES_W-1:0]       adc_data,
  input  logic                   tmp_wr,
  input  logic [RES_W+SUB_W-1:0] tmp_data,
  input  logic                   cs_n,
  input  logic                   sclk,
  output logic                   sdo,
  output logic [CW-1:0]          adc_count,
  output logic                   tmp_valid
);
  logic [RES_W-1:0]       head_data;
  logic [RES_W+SUB_W-1:0] tmp_val;
  logic [FRAME_W-1:0]     word;
  logic                   load_evt, done_evt, adc_ovw, adc_pop, adc_popped;
  logic                   tmp_sel, tmp_rel, claim_q;
  src_e                   sel_src, src_q;

  always_comb begin
    if (tmp_valid)            sel_src = SRC_TMP;
    else if (adc_count != '0) sel_src = SRC_ADC;
    else                      sel_src = SRC_NONE;
    case (sel_src)
      SRC_TMP: word = tmp_frame(tmp_val);
      SRC_ADC: word = adc_frame(head_data);
      default: word = '0;
    endcase
  end

  assign tmp_sel = load_evt && (sel_src == SRC_TMP);
  assign tmp_rel = done_evt && (src_q == SRC_TMP);
  assign adc_pop = done_evt && (src_q == SRC_ADC) && claim_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q   <= SRC_NONE;
      claim_q <= 1'b0;
    end else if (load_evt) begin
      src_q   <= sel_src;
      claim_q <= (sel_src == SRC_ADC) && !adc_ovw;
    end else if (adc_ovw || adc_pop) begin
      claim_q <= 1'b0;
    end
  end

  rfs_ring #(.DEPTH(DEPTH), .W(RES_W)) u_ring (
    .clk(clk), .rst_n(rst_n), .push(adc_wr), .din(adc_data), .pop(adc_pop),
    .dout(head_data), .count(adc_count), .ovw(adc_ovw), .popped(adc_popped)
  );

  rfs_tslot #(.TW(RES_W + SUB_W)) u_tslot (
    .clk(clk), .rst_n(rst_n), .wr(tmp_wr), .din(tmp_data), .sel(tmp_sel),
    .rel(tmp_rel), .valid(tmp_valid), .dout(tmp_val)
  );

  rfs_shifter #(.FW(FRAME_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .word(word),
    .load(load_evt), .done(done_evt), .sdo(sdo)
  );
endmodule

// File: rtl/rfs_checker.sv
module rfs_checker #(
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          adc_wr,
  input logic          tmp_wr,
  input logic          cs_n,
  input logic          sdo,
  input logic [CW-1:0] adc_count,
  input logic          tmp_valid,
  input logic          load_evt,
  input logic          done_evt,
  input logic          adc_pop,
  input logic          adc_popped
);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  assert_count_max_R1: assert property (@(posedge clk) disable iff (!rst_n)
    adc_count <= FULL);

  assert_full_keep_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (adc_wr && adc_count == FULL) |=> adc_count == FULL);

  assert_lead_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> !sdo);

  assert_tmp_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tmp_wr |=> tmp_valid);

  assert_cs_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sdo);

  assert_pop_on_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    adc_popped |-> (done_evt && adc_pop && !cs_n));

  assert_simul_keep_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (adc_popped && adc_wr) |=> adc_count == $past(adc_count));
endmodule

bind result_fifo_serial rfs_checker #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .adc_wr(adc_wr), .tmp_wr(tmp_wr), .cs_n(cs_n),
  .sdo(sdo), .adc_count(adc_count), .tmp_valid(tmp_valid), .load_evt(load_evt),
  .done_evt(done_evt), .adc_pop(adc_pop), .adc_popped(adc_popped)
);

// File: tb/sim_result_fifo_serial.sv
`timescale 1ns/1ps
module sim_result_fifo_serial;
  logic       clk = 0, rst_n = 0;
  logic       adc_wr = 0, tmp_wr = 0, cs_n = 1, sclk = 0;
  logic [9:0] adc_data = 0;
  logic [11:0] tmp_data = 0;
  logic       sdo;
  logic [4:0] adc_count;
  logic       tmp_valid;

  int vecs = 0, miss = 0;
  bit finished = 0;
  string cur_tag = "R12";

  always #5 clk = ~clk;

  result_fifo_serial u0 (.clk(clk), .rst_n(rst_n), .adc_wr(adc_wr), .adc_data(adc_data),
    .tmp_wr(tmp_wr), .tmp_data(tmp_data), .cs_n(cs_n), .sclk(sclk), .sdo(sdo),
    .adc_count(adc_count), .tmp_valid(tmp_valid));

  // behavioural reference model
  int          mq[$];
  bit          m_tv, m_fresh, m_act, m_claim, m_pcs, m_psc;
  logic [11:0] m_tval;
  logic [15:0] m_word;
  int          m_rise, m_src;

  always @(posedge clk) begin
    bit fcs, rs, fs, dn;
    if (!rst_n) begin
      mq.delete(); m_tv = 0; m_fresh = 0; m_act = 0; m_claim = 0;
      m_pcs = 1; m_psc = 0; m_tval = 0; m_word = 0; m_rise = 0; m_src = 0;
    end else begin
      fcs = m_pcs && !cs_n;
      rs  = !m_psc && sclk && !cs_n;
      fs  = m_psc && !sclk && !cs_n;
      dn  = 0;
      if (cs_n) m_act = 0;
      if (fcs) begin
        m_act = 1; m_rise = 0;
        if (m_tv) begin m_word = {4'b0, m_tval}; m_src = 1; m_fresh = 0; end
        else if (mq.size() > 0) begin m_word = 16'(mq[0] * 4); m_src = 2; m_claim = 1; end
        else begin m_word = 0; m_src = 0; end
      end else begin
        if (rs && m_rise < 16) begin m_rise++; dn = (m_rise == 16); end
        if (fs) m_word = m_word << 1;
      end
      if (dn) begin
        if (m_src == 1 && !m_fresh) m_tv = 0;
        if (m_src == 2 && m_claim) begin void'(mq.pop_front()); m_claim = 0; end
      end
      if (tmp_wr) begin m_tval = tmp_data; m_tv = 1; m_fresh = 1; end
      if (adc_wr) begin
        if (mq.size() == 16) begin void'(mq.pop_front()); m_claim = 0; end
        mq.push_back(int'(adc_data));
      end
      m_pcs = cs_n; m_psc = sclk;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      vecs++;
      if (sdo !== (m_act && !cs_n && m_word[15]) || adc_count !== 5'(mq.size()) || tmp_valid !== m_tv) begin
        miss++;
        $display("FAIL %s per-cycle: sdo=%b cnt=%0d tv=%b expected sdo=%b cnt=%0d tv=%b",
          cur_tag, sdo, adc_count, tmp_valid, m_act && !cs_n && m_word[15], mq.size(), m_tv);
      end
    end
  end

  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic chk(input string tag, input int got, input int exp);
    vecs++;
    if (got !== exp) begin
      miss++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic push_adc(input int d);
    adc_wr = 1; adc_data = 10'(d); step(); adc_wr = 0;
  endtask

  task automatic push_tmp(input int t);
    tmp_wr = 1; tmp_data = 12'(t); step(); tmp_wr = 0;
  endtask

  task automatic frame(input int nbits, input bit wr_end, input int wd, output logic [15:0] got);
    got = 0;
    cs_n = 0; step();
    for (int i = 0; i < nbits; i++) begin
      got[15-i] = sdo;
      sclk = 1;
      if (wr_end && i == 15) begin adc_wr = 1; adc_data = 10'(wd); end
      step();
      adc_wr = 0;
      sclk = 0; step();
    end
    cs_n = 1; step(); step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1; miss++;
      $display("FAIL watchdog: run did not complete");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
      $finish;
    end
  end

  initial begin
    logic [15:0] w;
    int exp_q[$];
    repeat (3) step();
    chk("R12 sdo in reset", sdo, 0);
    rst_n = 1; step();
    chk("R12 count", adc_count, 0);
    chk("R12 tmp_valid", tmp_valid, 0);
    chk("R12 sdo", sdo, 0);

    cur_tag = "R9";
    frame(16, 0, 0, w); chk("R9 empty frame", w, 0);

    cur_tag = "R7";
    push_adc('h155); push_adc('h2AA); push_adc('h001);
    chk("R1 count after three", adc_count, 3);
    frame(16, 0, 0, w); chk("R3/R7 first frame", w, 'h155 * 4);
    chk("R10 count after full frame", adc_count, 2);

    cur_tag = "R5";
    push_tmp('hABC);
    chk("R6 tmp_valid set", tmp_valid, 1);
    frame(16, 0, 0, w); chk("R4/R5 temperature first", w, 'h0ABC);
    chk("R10 temp slot cleared", tmp_valid, 0);
    frame(16, 0, 0, w); chk("R3 queued after temp", w, 'h2AA * 4);

    cur_tag = "R6";
    push_tmp('h111); push_tmp('h222);
    frame(16, 0, 0, w); chk("R6 newest temperature", w, 'h222);
    frame(16, 0, 0, w); chk("R3 last queued", w, 'h001 * 4);
    chk("R1 empty again", adc_count, 0);

    cur_tag = "R10";
    push_adc('h3FF);
    frame(8, 0, 0, w); chk("R10 partial bits", w, 'h0F00);
    chk("R10 aborted keeps entry", adc_count, 1);
    frame(16, 0, 0, w); chk("R10 reread after abort", w, 'h3FF * 4);

    cur_tag = "R2";
    for (int i = 1; i <= 18; i++) push_adc(i * 7);
    chk("R1 saturates at 16", adc_count, 16);
    frame(16, 0, 0, w); chk("R2 oldest overwritten", w, 3 * 7 * 4);

    cur_tag = "R11";
    push_adc(133);
    chk("R2 full again", adc_count, 16);
    frame(16, 1, 'h300, w); chk("R11 frame with write", w, 4 * 7 * 4);
    chk("R11 count kept", adc_count, 16);
    for (int i = 5; i <= 18; i++) exp_q.push_back(i * 7);
    exp_q.push_back(133); exp_q.push_back('h300);
    foreach (exp_q[k]) begin
      frame(16, 0, 0, w); chk("R11 drain order", w, exp_q[k] * 4);
    end
    chk("R11 drained", adc_count, 0);

    cur_tag = "R8";
    push_tmp('h5A5);
    for (int i = 0; i < 4; i++) begin sclk = ~sclk; step(); chk("R8 idle output", sdo, 0); end
    sclk = 0; step();

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  end
endmodule